// File: doc/BRIEF.md
# Handshake Command/Response Sequencer

This block sits behind a byte-wide serial shift port and a pair of active-low handshake lines held in a port-B style register. A host moves one byte per handshake. It pulls the request line low, and the sequencer answers by pulling the acknowledge line low. The host then lets request go high, and the sequencer lets acknowledge go high. The first byte of a transaction names a command. An external length lookup tells the sequencer how many argument bytes follow and how many response bytes go back. Either count may be marked variable, in which case the count travels as an extra byte on the wire.

Once every argument has arrived, the sequencer gives the external command handler a one-cycle dispatch strobe. It exposes the collected arguments through a read port and waits for a done pulse that carries the response size. The handler fills a response buffer through a write port. The sequencer then hands the response bytes to the host one per handshake, and returns to idle after the last one. Each byte it accepts raises a one-cycle shift-done pulse.

Top module: `handshake_cmd_seq`

## Requirements
- R1: After reset the port-B register reads 0x18, with acknowledge (bit 3) and request (bit 4) both high. The shift-done pulse and the dispatch strobe are low, and the sequencer is idle.
- R2: The sequencer evaluates port B only in a cycle with no host write, and only when the register differs from the value it last recorded. Its own acknowledge updates are recorded, so an unchanged register causes no action.
- R3: A changed value with request high and acknowledge low raises acknowledge and does nothing else. A changed value with both lines high, or with both lines low, changes nothing.
- R4: A changed value with request low and acknowledge high is a byte request. The sequencer drives acknowledge low, whatever the state and the shift direction.
- R5: In idle, a request with the direction flag at 1 (host to device) takes the shifted byte as the command and latches its two table lengths. With the flag at 0 the byte is ignored, no pulse is given and the state stays idle.
- R6: While receiving, a variable argument length makes the next byte the length. Otherwise each byte is stored at the next index while the index is below CMD_DEPTH. Bytes beyond CMD_DEPTH are dropped but still counted.
- R7: Dispatch happens when the received count reaches the argument length. This includes the command byte itself when the fixed length is 0, and a variable length byte of 0. Dispatch is a one-cycle strobe together with the command and the length. Port B is not evaluated until the done input arrives.
- R8: At done, the response size is taken from the size input, or is 0 when the unknown flag is set. A fixed response length of 0 returns the sequencer straight to idle.
- R9: While sending, a request needs the direction flag at 0. With the flag at 1 the request is ignored and no pulse is given. A variable response length sends the size first and then uses the size as the length. Each later byte is the stored response byte, or 0 when its index is at or past the size or RSP_DEPTH.
- R10: Every accepted byte, in either direction, gives exactly one single-cycle shift-done pulse. Rejected bytes give none.
- R11: After the byte that brings the sent count up to the response length, the sequencer is idle and takes the next byte as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pb_wr | input | 1 | Host write strobe for the port-B register |
| pb_wdata | input | 8 | Host write data for port B |
| pb_q | output | 8 | Port-B register; bit 3 acknowledge, bit 4 request, both active low |
| sr_in | input | 8 | Byte shifted in by the host |
| sr_host_tx | input | 1 | Shift direction: 1 host to device, 0 device to host |
| sr_out | output | 8 | Byte presented to the host |
| sr_done | output | 1 | One-cycle pulse per accepted byte |
| lk_cmd | output | 8 | Command being looked up |
| lk_arg_len | input | 8 | Fixed argument length for lk_cmd |
| lk_arg_var | input | 1 | Argument length travels as a byte |
| lk_rsp_len | input | 8 | Fixed response length for lk_cmd |
| lk_rsp_var | input | 1 | Response length travels as a byte |
| disp_stb | output | 1 | One-cycle dispatch strobe |
| disp_cmd | output | 8 | Command being dispatched |
| disp_len | output | 8 | Argument count of the dispatched command |
| arg_idx | input | $clog2(CMD_DEPTH) | Argument read index |
| arg_data | output | 8 | Argument byte at arg_idx |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_widx | input | $clog2(RSP_DEPTH) | Response buffer write index |
| rsp_wdata | input | 8 | Response buffer write data |
| disp_done | input | 1 | Handler finished |
| disp_unk | input | 1 | Handler did not recognise the command |
| disp_size | input | 8 | Response size from the handler |

## Verification
The bench builds the block with CMD_DEPTH and RSP_DEPTH both set to 4. This lets a six-argument command overrun the argument store. It also lets a six-byte response run past the response store, so the drop path and the zero-fill path are both covered by short transfers. The lookup model in the bench covers fixed, zero and variable lengths in both directions, and the bench stretches the dispatch wait to show that handshakes are held off during it.

// File: rtl/handshake_cmd_seq.sv
module handshake_cmd_seq #(
  parameter int CMD_DEPTH = 32,
  parameter int RSP_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pb_wr,
  input  logic [7:0]                   pb_wdata,
  output logic [7:0]                   pb_q,
  input  logic [7:0]                   sr_in,
  input  logic                         sr_host_tx,
  output logic [7:0]                   sr_out,
  output logic                         sr_done,
  output logic [7:0]                   lk_cmd,
  input  logic [7:0]                   lk_arg_len,
  input  logic                         lk_arg_var,
  input  logic [7:0]                   lk_rsp_len,
  input  logic                         lk_rsp_var,
  output logic                         disp_stb,
  output logic [7:0]                   disp_cmd,
  output logic [7:0]                   disp_len,
  input  logic [$clog2(CMD_DEPTH)-1:0] arg_idx,
  output logic [7:0]                   arg_data,
  input  logic                         rsp_we,
  input  logic [$clog2(RSP_DEPTH)-1:0] rsp_widx,
  input  logic [7:0]                   rsp_wdata,
  input  logic                         disp_done,
  input  logic                         disp_unk,
  input  logic [7:0]                   disp_size
);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int RAW = $clog2(RSP_DEPTH);
  localparam int ACK = 3;
  localparam int REQ = 4;
  localparam logic [7:0] ACK_M   = 8'(1 << ACK);
  localparam logic [7:0] IDLE_PB = 8'((1 << ACK) | (1 << REQ));
  localparam logic [8:0] CMD_LIM = 9'(CMD_DEPTH);
  localparam logic [8:0] RSP_LIM = 9'(RSP_DEPTH);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CMD = 2'd1, S_WAIT = 2'd2, S_RSP = 2'd3} st_t;

  st_t        st;
  logic [7:0] last_b;
  logic [7:0] cmd_q, cmd_len, rsp_len, rsp_size, rx_cnt, tx_cnt;
  logic       cmd_var, rsp_var;
  logic [7:0] cmd_buf [CMD_DEPTH];
  logic [7:0] rsp_buf [RSP_DEPTH];

  logic       eval, valid_req, ack_rel;
  logic       take_cmd, take_arg, give;
  logic       go_disp, go_idle;
  logic [7:0] rx_next, tx_next, tx_byte;
  logic       tx_in_range;

  assign eval      = !pb_wr && (st != S_WAIT) && (pb_q != last_b);
  assign valid_req = eval && (pb_q[REQ:ACK] == 2'b01);
  assign ack_rel   = eval && (pb_q[REQ:ACK] == 2'b10);

  assign take_cmd = valid_req && (st == S_IDLE) && sr_host_tx;
  assign take_arg = valid_req && (st == S_CMD) && sr_host_tx;
  assign give     = valid_req && (st == S_RSP) && !sr_host_tx;

  assign rx_next = rx_cnt + 8'd1;
  assign tx_next = tx_cnt + 8'd1;

  assign go_disp = (take_cmd && !lk_arg_var && (lk_arg_len == 8'd0)) ||
                   (take_arg && (cmd_var ? (sr_in == 8'd0) : (rx_next == cmd_len)));
  assign go_idle = give && (rsp_var ? (rsp_size == 8'd0) : (tx_next == rsp_len));

  assign tx_in_range = ({1'b0, tx_cnt} < {1'b0, rsp_size}) && ({1'b0, tx_cnt} < RSP_LIM);
  assign tx_byte = rsp_var ? rsp_size :
                   (tx_in_range ? rsp_buf[tx_cnt[RAW-1:0]] : 8'd0);

  assign lk_cmd   = sr_in;
  assign disp_cmd = cmd_q;
  assign disp_len = cmd_len;
  assign arg_data = cmd_buf[arg_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q   <= IDLE_PB;
      last_b <= IDLE_PB;
    end else begin
      if (pb_wr)          pb_q <= pb_wdata;
      else if (ack_rel)   pb_q <= pb_q | ACK_M;
      else if (valid_req) pb_q <= pb_q & ~ACK_M;
      if (eval) begin
        if (ack_rel)        last_b <= pb_q | ACK_M;
        else if (valid_req) last_b <= pb_q & ~ACK_M;
        else                last_b <= pb_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd_q    <= '0;
      cmd_len  <= '0;
      cmd_var  <= 1'b0;
      rsp_len  <= '0;
      rsp_var  <= 1'b0;
      rsp_size <= '0;
      rx_cnt   <= '0;
      tx_cnt   <= '0;
      sr_out   <= '0;
      sr_done  <= 1'b0;
      disp_stb <= 1'b0;
    end else begin
      sr_done  <= take_cmd || take_arg || give;
      disp_stb <= go_disp;
      if (take_cmd) begin
        cmd_q   <= sr_in;
        cmd_len <= lk_arg_len;
        cmd_var <= lk_arg_var;
        rsp_len <= lk_rsp_len;
        rsp_var <= lk_rsp_var;
        rx_cnt  <= '0;
        tx_cnt  <= '0;
        st      <= go_disp ? S_WAIT : S_CMD;
      end
      if (take_arg) begin
        if (cmd_var) begin
          cmd_len <= sr_in;
          cmd_var <= 1'b0;
        end else begin
          rx_cnt <= rx_next;
        end
        if (go_disp) st <= S_WAIT;
      end
      if ((st == S_WAIT) && disp_done) begin
        rsp_size <= disp_unk ? 8'd0 : disp_size;
        st       <= (!rsp_var && (rsp_len == 8'd0)) ? S_IDLE : S_RSP;
      end
      if (give) begin
        sr_out <= tx_byte;
        if (rsp_var) begin
          rsp_len <= rsp_size;
          rsp_var <= 1'b0;
        end else begin
          tx_cnt <= tx_next;
        end
        if (go_idle) st <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CMD_DEPTH; i++) cmd_buf[i] <= '0;
    end else if (take_arg && !cmd_var && ({1'b0, rx_cnt} < CMD_LIM)) begin
      cmd_buf[rx_cnt[CAW-1:0]] <= sr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RSP_DEPTH; i++) rsp_buf[i] <= '0;
    end else if (rsp_we) begin
      rsp_buf[rsp_widx] <= rsp_wdata;
    end
  end
endmodule

// File: rtl/handshake_cmd_seq_chk.sv
module handshake_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pb_wr,
  input logic [7:0] pb_q,
  input logic [7:0] last_b,
  input logic [1:0] st,
  input logic       sr_done,
  input logic       disp_stb,
  input logic       sr_host_tx,
  input logic       disp_done
);
  localparam logic [1:0] C_IDLE = 2'd0;
  localparam logic [1:0] C_WAIT = 2'd2;

  logic changed;
  assign changed = !pb_wr && (pb_q != last_b);

  a_r2_no_change_no_action: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_wr && (pb_q == last_b)) |=> ($stable(pb_q) && !sr_done && !disp_stb));

  a_r3_release_raises_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && (st != C_WAIT) && (pb_q[4:3] == 2'b10)) |=> (pb_q[3] && !sr_done));

  a_r4_request_lowers_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && (st != C_WAIT) && (pb_q[4:3] == 2'b01)) |=> !pb_q[3]);

  a_r5_wrong_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && (st == C_IDLE) && (pb_q[4:3] == 2'b01) && !sr_host_tx) |=> (!sr_done && (st == C_IDLE)));

  a_r7_hold_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == C_WAIT) && !disp_done && !pb_wr) |=> ($stable(pb_q) && !sr_done));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stb |=> !disp_stb);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sr_done |=> !sr_done);
endmodule

bind handshake_cmd_seq handshake_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_q(pb_q), .last_b(last_b),
  .st(st), .sr_done(sr_done), .disp_stb(disp_stb), .sr_host_tx(sr_host_tx),
  .disp_done(disp_done)
);

// File: tb/handshake_cmd_seq_tb.sv
module handshake_cmd_seq_tb;
  localparam int CLK_P = 10;
  localparam int CD = 4;
  localparam int RD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pb_wr = 1'b0;
  logic [7:0] pb_wdata = '0;
  logic [7:0] pb_q;
  logic [7:0] sr_in = '0;
  logic sr_host_tx = 1'b1;
  logic [7:0] sr_out;
  logic sr_done;
  logic [7:0] lk_cmd;
  logic [7:0] lk_arg_len, lk_rsp_len;
  logic lk_arg_var, lk_rsp_var;
  logic disp_stb;
  logic [7:0] disp_cmd, disp_len;
  logic [$clog2(CD)-1:0] arg_idx = '0;
  logic [7:0] arg_data;
  logic rsp_we = 1'b0;
  logic [$clog2(RD)-1:0] rsp_widx = '0;
  logic [7:0] rsp_wdata = '0;
  logic disp_done = 1'b0, disp_unk = 1'b0;
  logic [7:0] disp_size = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  handshake_cmd_seq #(.CMD_DEPTH(CD), .RSP_DEPTH(RD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata), .pb_q(pb_q),
    .sr_in(sr_in), .sr_host_tx(sr_host_tx), .sr_out(sr_out), .sr_done(sr_done),
    .lk_cmd(lk_cmd), .lk_arg_len(lk_arg_len), .lk_arg_var(lk_arg_var),
    .lk_rsp_len(lk_rsp_len), .lk_rsp_var(lk_rsp_var), .disp_stb(disp_stb),
    .disp_cmd(disp_cmd), .disp_len(disp_len), .arg_idx(arg_idx), .arg_data(arg_data),
    .rsp_we(rsp_we), .rsp_widx(rsp_widx), .rsp_wdata(rsp_wdata),
    .disp_done(disp_done), .disp_unk(disp_unk), .disp_size(disp_size)
  );

  always_comb begin
    lk_arg_len = 8'd0; lk_arg_var = 1'b0; lk_rsp_len = 8'd0; lk_rsp_var = 1'b0;
    case (lk_cmd)
      8'h10: begin lk_arg_len = 8'd2; lk_rsp_len = 8'd3; end
      8'h20: begin lk_arg_var = 1'b1; lk_rsp_var = 1'b1; end
      8'h40: begin lk_rsp_len = 8'd2; end
      8'h50: begin lk_arg_len = 8'd6; lk_rsp_var = 1'b1; end
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] v);
    @(negedge clk); pb_wr = 1'b1; pb_wdata = v;
    @(negedge clk); pb_wr = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, input bit dir,
                      output logic [7:0] got, output bit pulse, output bit stb);
    logic [7:0] v;
    @(negedge clk); sr_in = d; sr_host_tx = dir;
    v = pb_q; v[4] = 1'b0;
    host_wr(v);
    @(negedge clk);
    got = sr_out; pulse = sr_done; stb = disp_stb;
  endtask

  task automatic rel();
    logic [7:0] v;
    v = pb_q; v[4] = 1'b1;
    host_wr(v);
    @(negedge clk);
  endtask

  task automatic wr_rsp(input int i, input logic [7:0] d);
    @(negedge clk); rsp_we = 1'b1; rsp_widx = i[$clog2(RD)-1:0]; rsp_wdata = d;
    @(negedge clk); rsp_we = 1'b0;
  endtask

  task automatic finish_disp(input logic [7:0] sz, input bit unk);
    @(negedge clk); disp_done = 1'b1; disp_size = sz; disp_unk = unk;
    @(negedge clk); disp_done = 1'b0; disp_unk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pb_q == 8'h18, "R1 port B reset", pb_q, 8'h18);
    chk(!sr_done && !disp_stb, "R1 pulses low", {sr_done, disp_stb}, 0);
  endtask

  task automatic t_fixed();
    logic [7:0] g; bit p, s;
    xfer(8'h10, 1'b1, g, p, s);
    chk(p, "R10 cmd pulse", p, 1);
    chk(pb_q == 8'h00, "R4 ack low", pb_q, 8'h00);
    rel();
    chk(pb_q == 8'h18, "R3 ack released", pb_q, 8'h18);
    xfer(8'hAA, 1'b1, g, p, s); chk(!s, "R7 no early dispatch", s, 0); rel();
    xfer(8'hBB, 1'b1, g, p, s);
    chk(s, "R7 dispatch strobe", s, 1);
    chk(disp_cmd == 8'h10 && disp_len == 8'd2, "R7 dispatch cmd/len", {disp_cmd, disp_len}, 16'h1002);
    arg_idx = 0; #1 chk(arg_data == 8'hAA, "R6 arg0", arg_data, 8'hAA);
    arg_idx = 1; #1 chk(arg_data == 8'hBB, "R6 arg1", arg_data, 8'hBB);
    rel();
    repeat (3) @(negedge clk);
    chk(pb_q == 8'h10, "R7 held in wait", pb_q, 8'h10);
    wr_rsp(0, 8'h11); wr_rsp(1, 8'h22); wr_rsp(2, 8'h33);
    finish_disp(8'd3, 1'b0);
    chk(pb_q == 8'h18, "R7 release after done", pb_q, 8'h18);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, 1'b0, g, p, s);
      chk(p && g == 8'(8'h11 * (i + 1)), "R9 fixed response byte", g, 8'h11 * (i + 1));
      rel();
    end
  endtask

  task automatic t_zero();
    logic [7:0] g; bit p, s;
    xfer(8'h30, 1'b1, g, p, s);
    chk(s && p, "R11 idle then R7 zero-length dispatch", {s, p}, 2'b11);
    rel();
    finish_disp(8'd0, 1'b0);
    chk(pb_q == 8'h18, "R8 zero response idle", pb_q, 8'h18);
  endtask

  task automatic t_var();
    logic [7:0] g; bit p, s;
    xfer(8'h20, 1'b1, g, p, s); rel();
    xfer(8'h03, 1'b1, g, p, s); chk(p && !s, "R6 length byte", {p, s}, 2'b10); rel();
    for (int i = 1; i <= 3; i++) begin
      xfer(8'(i), 1'b1, g, p, s); rel();
    end
    chk(disp_len == 8'd3, "R6 variable length latched", disp_len, 3);
    wr_rsp(0, 8'h5A); wr_rsp(1, 8'hA5);
    finish_disp(8'd2, 1'b0);
    xfer(8'h00, 1'b1, g, p, s);
    chk(!p, "R9 wrong direction in send", p, 0);
    rel();
    xfer(8'h00, 1'b0, g, p, s); chk(p && g == 8'd2, "R9 size first", g, 2); rel();
    xfer(8'h00, 1'b0, g, p, s); chk(g == 8'h5A, "R9 var byte0", g, 8'h5A); rel();
    xfer(8'h00, 1'b0, g, p, s); chk(g == 8'hA5, "R9 var byte1", g, 8'hA5); rel();
    xfer(8'h20, 1'b1, g, p, s); rel();
    xfer(8'h00, 1'b1, g, p, s);
    chk(s, "R7 variable length zero dispatch", s, 1);
    rel();
    finish_disp(8'd0, 1'b0);
    xfer(8'h00, 1'b0, g, p, s); chk(p && g == 8'd0, "R9 size zero", g, 0); rel();
    xfer(8'h30, 1'b1, g, p, s); chk(s, "R11 idle after size zero", s, 1); rel();
    finish_disp(8'd0, 1'b0);
  endtask

  task automatic t_unknown();
    logic [7:0] g; bit p, s;
    wr_rsp(0, 8'h77); wr_rsp(1, 8'h66);
    xfer(8'h40, 1'b1, g, p, s); rel();
    finish_disp(8'd5, 1'b1);
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, 1'b0, g, p, s); chk(p && g == 8'd0, "R8 unknown gives zeros", g, 0); rel();
    end
  endtask

  task automatic t_overflow();
    logic [7:0] g; bit p, s;
    xfer(8'h50, 1'b1, g, p, s); rel();
    for (int i = 1; i <= 6; i++) begin
      xfer(8'(i), 1'b1, g, p, s);
      chk(s == (i == 6), "R6 count includes dropped", s, i == 6);
      rel();
    end
    arg_idx = 3; #1 chk(arg_data == 8'd4, "R6 last stored arg", arg_data, 4);
    for (int i = 0; i < 4; i++) wr_rsp(i, 8'(8'hC0 + i));
    finish_disp(8'd6, 1'b0);
    xfer(8'h00, 1'b0, g, p, s); chk(g == 8'd6, "R9 size 6", g, 6); rel();
    for (int i = 0; i < 6; i++) begin
      xfer(8'h00, 1'b0, g, p, s);
      chk(g == ((i < 4) ? 8'(8'hC0 + i) : 8'h00), "R9 capacity zero fill", g, (i < 4) ? 8'hC0 + i : 0);
      rel();
    end
  endtask

  task automatic t_protocol();
    logic [7:0] g; bit p, s;
    xfer(8'h10, 1'b0, g, p, s);
    chk(!p && pb_q == 8'h00, "R5 wrong direction ignored", {p, pb_q}, 0);
    host_wr(8'h00); @(negedge clk);
    chk(!sr_done && pb_q == 8'h00, "R2 unchanged value no action", {sr_done, pb_q}, 0);
    rel();
    xfer(8'h30, 1'b1, g, p, s);
    chk(s, "R5 idle kept after wrong direction", s, 1);
    rel();
    finish_disp(8'd0, 1'b0);
    host_wr(8'h00); repeat (2) @(negedge clk);
    chk(!sr_done && pb_q == 8'h00, "R3 both low ignored", {sr_done, pb_q}, 0);
    host_wr(8'h18); @(negedge clk);
    chk(pb_q == 8'h18 && !sr_done, "R3 both high idle", pb_q, 8'h18);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_zero();
    t_var();
    t_unknown();
    t_overflow();
    t_protocol();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule